// File: doc/BRIEF.md
# Reed-Solomon Parity Engine for 512-Byte Flash Pages

This block watches the byte stream that passes between a host and a flash array and computes Reed-Solomon check symbols over one page. The code works on 10-bit symbols in GF(2^10). Each data byte is inverted and then extended to one symbol. The generator has six roots, so a page carries six parity symbols, and these are packed into eight bytes for the spare area. Because bytes are inverted on entry, a fully erased page produces a parity readout that is all ones. That readout can then be written to flash unchanged.

Software drives the engine through a small register window. A control register clears the engine, picks generate or check operation and opens the byte feed. An inverted readout bank returns the parity bytes to store. In check operation the page is streamed back followed by its eight stored bytes. A status bit then reports whether the page and its parity disagree. A second readout bank shows the remainder with each byte bit-reversed, for use by a software decoder. Locating and correcting errors is left to software.

Top module: `nand_rs_ecc`

## Requirements
- R1: After a generate pass, the parity symbols p5..p0 make the codeword zero at alpha^0..alpha^5 in GF(2^10) with x^10+x^3+1. The codeword is the data symbols {2'b00, ~byte} followed by p5 down to p0, and the first page byte has the highest degree.
- R2: The control register is at address 0. Bit 7 clears the byte count, the remainder and the captured parity. Bit 6 selects generate, and bit 5 enables the feed. Writing 0 stops accumulation without clearing anything. Reading address 0 returns bits 6 and 5 as written, with bit 7 reading 0.
- R3: A byte is absorbed only in a cycle where fl_valid is high, the feed is enabled, and no control write is taking place.
- R4: In generate operation, only the first PAGE_BYTES bytes are absorbed. Any bytes after them leave the parity unchanged.
- R5: The symbols are packed into a 64-bit word W as {4'b0, p0, p1, p2, p3, p4, p5}, so p5 sits in W[9:0]. Byte k of the packing is W[8k+7:8k].
- R6: Addresses 8+k (k = 0..7) return ~W byte k in bits 7:0, with bits 15:8 reading zero. The top nibble of byte 7 therefore reads as ones, and an all-0xFF page reads 0xFF in all eight bytes.
- R7: In check operation, the PAGE_BYTES data bytes are absorbed first. The next eight bytes are inverted and taken as a stored packed word, laid out as in R5. All later bytes are ignored.
- R8: Address 1 bit 7 reads 1 only after a complete check pass whose codeword, data plus stored parity, fails R1. In every other case it reads 0.
- R9: Addresses 16+k return byte k of the remainder (W xor the stored word) with its bit order reversed. In generate operation the stored word is zero.
- R10: After reset, addresses 0 and 1 read 0, addresses 8..15 read 0x00FF, and addresses 16..23 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| fl_valid | input | 1 | Flash byte strobe |
| fl_data | input | 8 | Flash data byte |

## Verification
The bench builds the engine with its default PAGE_BYTES of 512, so every pass spans a full page plus its spare bytes. The random pages and the directed pages (all 0x00 and all 0xFF) are checked against an independent root evaluation rather than a second encoder. The full page length brings several cases within reach: the limit on extra bytes, a pause and resume in the middle of a page, single-byte corruption in both the data and the parity, and the bit-reversed remainder readout.

// File: rtl/nand_rs_ecc.sv
module nand_rs_ecc #(
  parameter int PAGE_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        fl_valid,
  input  logic [7:0]  fl_data
);
  localparam int SW        = 10;
  localparam int SYMS      = 6;
  localparam int PAR_BYTES = 8;
  localparam int TOTAL     = PAGE_BYTES + PAR_BYTES;
  localparam int CW        = $clog2(TOTAL + 1);

  function automatic logic [SW-1:0] gf_mul(input logic [SW-1:0] a, input logic [SW-1:0] b);
    logic [SW-1:0] p, t;
    p = '0;
    t = a;
    for (int k = 0; k < SW; k++) begin
      if (b[k]) p = p ^ t;
      t = t[SW-1] ? ({t[SW-2:0], 1'b0} ^ 10'h009) : {t[SW-2:0], 1'b0};
    end
    return p;
  endfunction

  function automatic logic [SYMS-1:0][SW-1:0] gen_poly();
    logic [SYMS:0][SW-1:0] g;
    logic [SW-1:0] root;
    g = '0;
    g[0] = 10'd1;
    root = 10'd1;
    for (int i = 0; i < SYMS; i++) begin
      for (int j = SYMS; j > 0; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, 10'd2);
    end
    return g[SYMS-1:0];
  endfunction

  localparam logic [SYMS-1:0][SW-1:0] GEN = gen_poly();

  logic                      gen_q, feed_q;
  logic [CW-1:0]             cnt;
  logic [SYMS-1:0][SW-1:0]   par_q, par_d;
  logic [63:0]               cap_q;

  wire           ctrl_wr = reg_wr && (reg_addr == 5'd0);
  wire [CW-1:0]  lim     = gen_q ? CW'(PAGE_BYTES) : CW'(TOTAL);
  wire           take    = fl_valid && feed_q && (cnt < lim) && !ctrl_wr;
  wire           in_data = cnt < CW'(PAGE_BYTES);
  wire [2:0]     pidx    = 3'(cnt - CW'(PAGE_BYTES));
  wire [SW-1:0]  fb      = {2'b00, ~fl_data} ^ par_q[SYMS-1];
  wire           unused_wbits = ^reg_wdata[4:0];

  for (genvar i = 0; i < SYMS; i++) begin : g_tap
    if (i == 0) begin : g_low
      assign par_d[i] = gf_mul(fb, GEN[i]);
    end else begin : g_mid
      assign par_d[i] = par_q[i-1] ^ gf_mul(fb, GEN[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= 1'b0;
      feed_q <= 1'b0;
      cnt    <= '0;
      par_q  <= '0;
      cap_q  <= '0;
    end else if (ctrl_wr) begin
      gen_q  <= reg_wdata[6];
      feed_q <= reg_wdata[5];
      if (reg_wdata[7]) begin
        cnt   <= '0;
        par_q <= '0;
        cap_q <= '0;
      end
    end else if (take) begin
      cnt <= cnt + CW'(1);
      if (in_data) par_q <= par_d;
      else cap_q[{pidx, 3'b000} +: 8] <= ~fl_data;
    end
  end

  wire [63:0] pk_par = {4'h0, par_q[0], par_q[1], par_q[2], par_q[3], par_q[4], par_q[5]};
  wire [63:0] pk_rem = pk_par ^ cap_q;
  wire        done   = !gen_q && (cnt == CW'(TOTAL));
  wire        err    = done && (|pk_rem[59:0]);
  wire [2:0]  bsel   = reg_addr[2:0];
  wire [7:0]  rem_b  = pk_rem[{bsel, 3'b000} +: 8];

  logic [7:0] rev_b;
  always_comb
    for (int k = 0; k < 8; k++) rev_b[k] = rem_b[7-k];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr[4:3])
      2'b00: begin
        if (reg_addr[2:0] == 3'd0) reg_rdata[7:0] = {1'b0, gen_q, feed_q, 5'b0};
        else if (reg_addr[2:0] == 3'd1) reg_rdata[7:0] = {err, 7'b0};
      end
      2'b01: reg_rdata[7:0] = ~pk_par[{bsel, 3'b000} +: 8];
      2'b10: reg_rdata[7:0] = rev_b;
      default: reg_rdata = '0;
    endcase
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && reg_wdata[7] |=> cnt == '0 && par_q == '0 && cap_q == '0); // R2
  AST_HOLD_NOFEED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr && !(fl_valid && feed_q) |=> $stable(par_q) && $stable(cnt) && $stable(cap_q)); // R3
  AST_GEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr && gen_q && cnt >= CW'(PAGE_BYTES) |=> $stable(par_q) && $stable(cnt)); // R4
  AST_READ_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr && cnt == CW'(TOTAL) |=> $stable(par_q) && $stable(cap_q) && cnt == CW'(TOTAL)); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(TOTAL)); // R7
  AST_ERR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !gen_q && cnt == CW'(TOTAL)); // R8
endmodule

// File: tb/test_nand_rs_ecc.sv
`timescale 1ns/1ps
module test_nand_rs_ecc;
  localparam int PB = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        fl_valid = 1'b0;
  logic [7:0]  fl_data = '0;

  nand_rs_ecc #(.PAGE_BYTES(PB)) i_nand_rs_ecc (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fl_valid(fl_valid), .fl_data(fl_data));

  int tests = 0, fails = 0;
  int unsigned cyc = 0;
  logic [7:0]  pg [PB];
  logic [7:0]  stored [8];
  logic [63:0] pv, pv_ref;
  logic [15:0] rv;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] fmul(input logic [9:0] a, input logic [9:0] b);
    logic [18:0] p;
    p = '0;
    for (int k = 0; k < 10; k++) if (b[k]) p = p ^ (19'(a) << k);
    for (int k = 18; k >= 10; k--) if (p[k]) p = p ^ (19'h409 << (k - 10));
    return p[9:0];
  endfunction

  function automatic logic [7:0] brev(input logic [7:0] b);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = b[7-k];
    return r;
  endfunction

  function automatic bit roots_fail(input logic [63:0] w);
    logic [9:0] a, acc;
    bit bad;
    bad = 0;
    a = 10'd1;
    for (int i = 0; i < 6; i++) begin
      acc = '0;
      for (int n = 0; n < PB; n++) acc = fmul(acc, a) ^ {2'b00, ~pg[n]};
      for (int s = 0; s < 6; s++) acc = fmul(acc, a) ^ w[10*s +: 10];
      if (acc != 0) bad = 1;
      a = fmul(a, 10'd2);
    end
    return bad;
  endfunction

  task automatic wreg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); fl_valid = 1'b1; fl_data = b;
  endtask

  task automatic idle();
    @(negedge clk); fl_valid = 1'b0; fl_data = 8'($urandom);
  endtask

  task automatic send_range(input int lo, input int hi);
    for (int n = lo; n < hi; n++) push(pg[n]);
    idle();
  endtask

  task automatic read_par(output logic [63:0] w);
    logic [15:0] v;
    w = '0;
    for (int k = 0; k < 8; k++) begin
      rreg(5'(8 + k), v);
      stored[k] = v[7:0];
      w[8*k +: 8] = ~v[7:0];
      if (k == 0) chk("R6 upper half zero", 64'(v[15:8]), 64'h0);
    end
  endtask

  task automatic read_syn(output logic [63:0] s);
    logic [15:0] v;
    s = '0;
    for (int k = 0; k < 8; k++) begin
      rreg(5'(16 + k), v);
      s[8*k +: 8] = v[7:0];
    end
  endtask

  task automatic send_stored(input int k, input logic [7:0] m);
    for (int j = 0; j < 8; j++) push(stored[j] ^ ((j == k) ? m : 8'h00));
    idle();
  endtask

  initial begin
    wait (cyc >= 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] s, exp_syn;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    rreg(5'd0, rv); chk("R10 ctrl after reset", 64'(rv), 64'h0);
    rreg(5'd1, rv); chk("R10 status after reset", 64'(rv), 64'h0);
    read_par(pv);   chk("R10 parity readout after reset", ~pv, 64'hFFFF_FFFF_FFFF_FFFF);
    read_syn(s);    chk("R10 syndrome after reset", s, 64'h0);

    for (int p = 0; p < 5; p++) begin
      for (int n = 0; n < PB; n++)
        pg[n] = (p == 0) ? 8'hFF : (p == 1) ? 8'h00 : 8'($urandom);
      wreg(5'd0, 8'hE0);
      if (p == 0) begin
        rreg(5'd0, rv); chk("R2 ctrl readback", 64'(rv), 64'h60);
      end
      send_range(0, PB);
      read_par(pv);
      chk("R1 R5 roots of generated codeword", 64'(roots_fail(pv)), 64'h0);
      chk("R6 byte 7 top nibble ones", 64'(stored[7][7:4]), 64'hF);
      if (p == 0) chk("R6 erased page parity", ~pv, 64'hFFFF_FFFF_FFFF_FFFF);
      read_syn(s);
      exp_syn = '0;
      for (int k = 0; k < 8; k++) exp_syn[8*k +: 8] = brev(pv[8*k +: 8]);
      chk("R9 syndrome in generate mode", s, exp_syn);
      for (int e = 0; e < 5; e++) push(8'($urandom));
      idle();
      pv_ref = pv;
      read_par(pv);
      chk("R4 extra bytes ignored", pv, pv_ref);

      if (p >= 2) begin
        wreg(5'd0, 8'hA0);
        send_range(0, PB);
        rreg(5'd1, rv); chk("R8 no flag before parity", 64'(rv), 64'h0);
        send_stored(0, 8'h00);
        rreg(5'd1, rv); chk("R8 clean page flag", 64'(rv), 64'h0);
        read_syn(s);    chk("R9 clean remainder", s, 64'h0);
        for (int e = 0; e < 3; e++) push(8'($urandom));
        idle();
        rreg(5'd1, rv); chk("R7 bytes after parity ignored", 64'(rv), 64'h0);
        read_syn(s);    chk("R7 remainder unchanged", s, 64'h0);

        begin
          int k;
          logic [7:0] m;
          k = int'($urandom_range(0, 6));
          m = 8'($urandom_range(1, 255));
          wreg(5'd0, 8'hA0);
          send_range(0, PB);
          send_stored(k, m);
          rreg(5'd1, rv); chk("R8 parity corruption flagged", 64'(rv), 64'h80);
          read_syn(s);
          exp_syn = '0;
          exp_syn[8*k +: 8] = brev(m);
          chk("R9 remainder of parity corruption", s, exp_syn);
        end

        begin
          int j;
          logic [7:0] m;
          j = int'($urandom_range(0, PB - 1));
          m = 8'($urandom_range(1, 255));
          pg[j] = pg[j] ^ m;
          wreg(5'd0, 8'hA0);
          send_range(0, PB);
          send_stored(0, 8'h00);
          rreg(5'd1, rv);
          chk("R7 R8 data corruption flagged", 64'(rv), roots_fail(pv) ? 64'h80 : 64'h0);
          pg[j] = pg[j] ^ m;
        end
      end
    end

    for (int n = 0; n < PB; n++) pg[n] = 8'($urandom);
    wreg(5'd0, 8'hE0);
    send_range(0, PB);
    read_par(pv_ref);
    wreg(5'd0, 8'hE0);
    send_range(0, 200);
    wreg(5'd0, 8'h00);
    for (int e = 0; e < 10; e++) push(8'($urandom));
    idle();
    rreg(5'd0, rv); chk("R2 write zero stops feed", 64'(rv), 64'h0);
    wreg(5'd0, 8'h60);
    for (int e = 0; e < 4; e++) idle();
    send_range(200, PB);
    read_par(pv);
    chk("R3 paused feed resumes cleanly", pv, pv_ref);
    wreg(5'd0, 8'hE0);
    read_par(pv);
    chk("R2 clear empties parity", ~pv, 64'hFFFF_FFFF_FFFF_FFFF);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule